// File: doc/BRIEF.md
# CSI-2 Packet Header Event Detector

This block sits behind the header decoder of a CSI-2 receiver. For every received packet header, the decoder gives it a one-cycle strobe with the data type, the virtual channel, a two-bit ECC verdict, and a payload checksum mismatch flag. From these it raises single-cycle event pulses.

The per-channel events are frame start, frame end, line start, line end, payload checksum error and ECC-corrected. Each has one bit for each of channels 0 to 3. Two global pulses report a generic short packet and an uncorrectable header. The pulses are meant to feed an interrupt status collector.

The block classifies each data type as one of four kinds: sync short packet, reserved short packet, generic short packet, or long packet. It then gates each event by that kind and by the ECC verdict. A header whose ECC cannot be repaired carries no trustworthy type or channel. For such a header only the uncorrectable pulse fires.

Top module: `csi2_hdr_event_det`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output pulse is 0 after that edge.
- R2: A header with `ecc_status` not uncorrectable and data type 0x00, 0x01, 0x02 or 0x03 raises bit `hdr_vc` of `ev_fs`, `ev_fe`, `ev_ls` or `ev_le` respectively, on the clock edge after the strobe edge.
- R3: `ev_gen_short` pulses for data types 0x08 through 0x0F only. Sync types 0x00–0x03, reserved types 0x04–0x07 and long types never raise it.
- R4: With `ecc_status` = 2'b01 (single-bit error corrected), bit `hdr_vc` of `ev_ecc_fix` pulses for any short packet (data type below 0x10). Long packets never raise it.
- R5: With `ecc_status[1]` = 1 (uncorrectable), `ev_ecc_fatal` pulses for any data type and every other output stays 0 in that cycle. `ecc_status` = 2'b00 means clean.
- R6: A long packet (data type 0x10 or above) with `pay_crc_mismatch` = 1 raises bit `hdr_vc` of `ev_crc_err`. The flag is ignored for short packets.
- R7: When `hdr_vld` is 0, all outputs are 0 on the next edge, whatever the other inputs hold.
- R8: Each pulse lasts exactly one cycle per strobe. Back-to-back strobes give back-to-back pulses.
- R9: Per-channel events only ever set the bit of the addressed channel. Across the four sync outputs, at most one bit is set in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hdr_vld | input | 1 | One-cycle strobe: a decoded header is present |
| hdr_dt | input | 6 | Data type of the header |
| hdr_vc | input | 2 | Virtual channel of the header |
| ecc_status | input | 2 | 00 clean, 01 corrected single-bit, 1x uncorrectable |
| pay_crc_mismatch | input | 1 | Payload checksum mismatch (long packets) |
| ev_fs | output | 4 | Frame start pulse per channel |
| ev_fe | output | 4 | Frame end pulse per channel |
| ev_ls | output | 4 | Line start pulse per channel |
| ev_le | output | 4 | Line end pulse per channel |
| ev_crc_err | output | 4 | Payload checksum error pulse per channel |
| ev_ecc_fix | output | 4 | Header ECC corrected pulse per channel (short packets) |
| ev_gen_short | output | 1 | Generic short packet (types 0x08–0x0F) pulse |
| ev_ecc_fatal | output | 1 | Uncorrectable header ECC pulse |

## Verification
The assertions assume that the strobe and its fields are settled at the sampling edge. They also assume that the checksum flag accompanying a header belongs to that same packet. No assumption is made about how often strobes arrive, so back-to-back headers are legal. The stimulus drives each field on the falling edge and draws the data type, channel, ECC verdict and checksum flag independently from a seeded generator. This reaches every kind-by-verdict combination, including nonsense pairings such as a checksum flag on a short packet. It also mixes idle cycles carrying random fields with directed headers for each sync code on each channel and for the boundary types 0x03, 0x04, 0x07, 0x08, 0x0F and 0x10.

// File: rtl/csi2_evt_pkg.sv
// Package: shared constants and the packet-kind type for the header event detector.
// Assumes data types are unsigned and compared as integers.
package csi2_evt_pkg;

    // Sync short-packet codes; the low two bits select the sync event.
    localparam int DT_FRAME_START = 'h00;
    localparam int DT_FRAME_END   = 'h01;
    localparam int DT_LINE_START  = 'h02;
    localparam int DT_LINE_END    = 'h03;
    // Boundaries of the data type ranges.
    localparam int DT_GEN_LO      = 'h08;
    localparam int DT_GEN_HI      = 'h0F;
    localparam int DT_LONG_LO     = 'h10;

    // ECC verdict codes.
    localparam logic [1:0] ECC_CLEAN = 2'b00;
    localparam logic [1:0] ECC_FIXED = 2'b01;

    typedef enum logic [1:0] {
        KIND_SYNC     = 2'd0,
        KIND_RSVD     = 2'd1,
        KIND_GENERIC  = 2'd2,
        KIND_LONG     = 2'd3
    } pkt_kind_e;

    typedef enum logic [1:0] {
        SYNC_FS = 2'd0,
        SYNC_FE = 2'd1,
        SYNC_LS = 2'd2,
        SYNC_LE = 2'd3
    } sync_sel_e;

endpackage

// File: rtl/csi2_dt_classify.sv
// Module: sorts a data type into sync / reserved short / generic short / long,
// and names the sync event for sync types.
// Assumes DT_W is wide enough to hold the long-packet boundary (>= 5 bits).
module csi2_dt_classify
    import csi2_evt_pkg::*;
#(
    parameter int DT_W = 6
) (
    input  logic [DT_W-1:0] dt,
    output pkt_kind_e       kind,
    output sync_sel_e       sync_sel
);

    // Range decode of the data type into a packet kind.
    always_comb begin
        if (int'(dt) >= DT_LONG_LO)
            kind = KIND_LONG;
        else if (int'(dt) >= DT_GEN_LO && int'(dt) <= DT_GEN_HI)
            kind = KIND_GENERIC;
        else if (int'(dt) <= DT_LINE_END)
            kind = KIND_SYNC;
        else
            kind = KIND_RSVD;
    end

    // Sync event select from the low two bits (valid only for KIND_SYNC).
    always_comb begin
        unique case (dt[1:0])
            2'd0:    sync_sel = SYNC_FS;
            2'd1:    sync_sel = SYNC_FE;
            2'd2:    sync_sel = SYNC_LS;
            default: sync_sel = SYNC_LE;
        endcase
    end

endmodule

// File: rtl/csi2_vc_select.sv
// Module: turns a channel number into a one-hot channel vector, gated by an enable.
// Assumes NUM_VC = 2**VC_W.
module csi2_vc_select #(
    parameter int VC_W   = 2,
    parameter int NUM_VC = 1 << VC_W
) (
    input  logic              en,
    input  logic [VC_W-1:0]   vc,
    output logic [NUM_VC-1:0] hit
);

    for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
        // One comparator per channel.
        assign hit[v] = en && (int'(vc) == v);
    end

endmodule

// File: rtl/csi2_evt_stage.sv
// Module: qualifies each event by packet kind and ECC verdict, then registers the
// pulses once. Assumes hit is one-hot or zero and already gated by the strobe and a
// repairable header.
module csi2_evt_stage
    import csi2_evt_pkg::*;
#(
    parameter int NUM_VC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic              hdr_fatal,
    input  logic [NUM_VC-1:0] hit,
    input  pkt_kind_e         kind,
    input  sync_sel_e         sync_sel,
    input  logic              ecc_fixed,
    input  logic              crc_mismatch,
    output logic [NUM_VC-1:0] fs_q,
    output logic [NUM_VC-1:0] fe_q,
    output logic [NUM_VC-1:0] ls_q,
    output logic [NUM_VC-1:0] le_q,
    output logic [NUM_VC-1:0] crc_q,
    output logic [NUM_VC-1:0] fix_q,
    output logic              gen_q,
    output logic              fatal_q
);

    logic [NUM_VC-1:0] fs_d, fe_d, ls_d, le_d, crc_d, fix_d;
    logic              is_sync, is_long;
    logic              gen_d, fatal_d;

    assign is_sync = (kind == KIND_SYNC);
    assign is_long = (kind == KIND_LONG);

    for (genvar v = 0; v < NUM_VC; v++) begin : g_ch
        // Per-channel gating by packet kind and verdict.
        always_comb begin
            fs_d[v]  = hit[v] && is_sync && (sync_sel == SYNC_FS);
            fe_d[v]  = hit[v] && is_sync && (sync_sel == SYNC_FE);
            ls_d[v]  = hit[v] && is_sync && (sync_sel == SYNC_LS);
            le_d[v]  = hit[v] && is_sync && (sync_sel == SYNC_LE);
            crc_d[v] = hit[v] && is_long && crc_mismatch;
            fix_d[v] = hit[v] && !is_long && ecc_fixed;
        end
    end

    // Global events: generic short needs a usable header, fatal needs only the strobe.
    always_comb begin
        gen_d   = strobe && !hdr_fatal && (kind == KIND_GENERIC);
        fatal_d = strobe && hdr_fatal;
    end

    // Single register stage for every pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_q    <= '0;
            fe_q    <= '0;
            ls_q    <= '0;
            le_q    <= '0;
            crc_q   <= '0;
            fix_q   <= '0;
            gen_q   <= 1'b0;
            fatal_q <= 1'b0;
        end else begin
            fs_q    <= fs_d;
            fe_q    <= fe_d;
            ls_q    <= ls_d;
            le_q    <= le_d;
            crc_q   <= crc_d;
            fix_q   <= fix_d;
            gen_q   <= gen_d;
            fatal_q <= fatal_d;
        end
    end

    // R7: no strobe, no events one cycle later.
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> (fs_q == '0 && fe_q == '0 && ls_q == '0 && le_q == '0 &&
                     crc_q == '0 && fix_q == '0 && !gen_q && !fatal_q));

    // R5: an uncorrectable header gives only the fatal pulse.
    a_r5_fatal_alone: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && hdr_fatal) |=> (fatal_q && fs_q == '0 && fe_q == '0 && ls_q == '0 &&
                                   le_q == '0 && crc_q == '0 && fix_q == '0 && !gen_q));

    // R9: at most one sync event bit across all channels and codes.
    a_r9_sync_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fs_q, fe_q, ls_q, le_q}));

    // R9: per-channel events never name two channels at once.
    a_r9_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fs_q | fe_q | ls_q | le_q | crc_q | fix_q));

    // R4 / R6: corrected-ECC (short only) and checksum error (long only) exclude each other.
    a_r4_r6_kind_split: assert property (@(posedge clk) disable iff (!rst_n)
        !((|fix_q) && (|crc_q)));

    // R3: generic short packets never coincide with a sync event.
    a_r3_gen_not_sync: assert property (@(posedge clk) disable iff (!rst_n)
        gen_q |-> ((fs_q | fe_q | ls_q | le_q) == '0));

endmodule

// File: rtl/csi2_hdr_event_det.sv
// Module: top of the header event detector. Classifies each strobed header, selects
// its channel when the ECC verdict allows, and emits registered one-cycle pulses.
// Assumes ecc_status and pay_crc_mismatch are valid in the strobe cycle.
module csi2_hdr_event_det
    import csi2_evt_pkg::*;
#(
    parameter int DT_W   = 6,
    parameter int VC_W   = 2,
    parameter int NUM_VC = 1 << VC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hdr_vld,
    input  logic [DT_W-1:0]   hdr_dt,
    input  logic [VC_W-1:0]   hdr_vc,
    input  logic [1:0]        ecc_status,
    input  logic              pay_crc_mismatch,
    output logic [NUM_VC-1:0] ev_fs,
    output logic [NUM_VC-1:0] ev_fe,
    output logic [NUM_VC-1:0] ev_ls,
    output logic [NUM_VC-1:0] ev_le,
    output logic [NUM_VC-1:0] ev_crc_err,
    output logic [NUM_VC-1:0] ev_ecc_fix,
    output logic              ev_gen_short,
    output logic              ev_ecc_fatal
);

    pkt_kind_e         kind;
    sync_sel_e         sync_sel;
    logic              hdr_fatal;
    logic              hdr_fixed;
    logic [NUM_VC-1:0] vc_hit;

    // ECC verdict split: bit 1 marks uncorrectable, 01 marks a repaired header.
    always_comb begin
        hdr_fatal = ecc_status[1];
        hdr_fixed = (ecc_status == ECC_FIXED);
    end

    csi2_dt_classify #(.DT_W(DT_W)) u_cls (
        .dt       (hdr_dt),
        .kind     (kind),
        .sync_sel (sync_sel)
    );

    csi2_vc_select #(.VC_W(VC_W), .NUM_VC(NUM_VC)) u_vc (
        .en  (hdr_vld && !hdr_fatal),
        .vc  (hdr_vc),
        .hit (vc_hit)
    );

    csi2_evt_stage #(.NUM_VC(NUM_VC)) u_stage (
        .clk          (clk),
        .rst_n        (rst_n),
        .strobe       (hdr_vld),
        .hdr_fatal    (hdr_fatal),
        .hit          (vc_hit),
        .kind         (kind),
        .sync_sel     (sync_sel),
        .ecc_fixed    (hdr_fixed),
        .crc_mismatch (pay_crc_mismatch),
        .fs_q         (ev_fs),
        .fe_q         (ev_fe),
        .ls_q         (ev_ls),
        .le_q         (ev_le),
        .crc_q        (ev_crc_err),
        .fix_q        (ev_ecc_fix),
        .gen_q        (ev_gen_short),
        .fatal_q      (ev_ecc_fatal)
    );

    // R1: the cycle after a reset edge shows no events.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (ev_fs == '0 && ev_fe == '0 && ev_ls == '0 && ev_le == '0 &&
                    ev_crc_err == '0 && ev_ecc_fix == '0 && !ev_gen_short && !ev_ecc_fatal));

    // R2: a clean frame-start on a channel reaches that channel's bit.
    a_r2_fs_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_vld && !ecc_status[1] && int'(hdr_dt) == DT_FRAME_START)
            |=> (ev_fs == NUM_VC'(1) << $past(hdr_vc)));

endmodule

// File: tb/sim_csi2_hdr_event_det.sv
module sim_csi2_hdr_event_det;

    localparam int NV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hdr_vld = 1'b0;
    logic [5:0] hdr_dt = '0;
    logic [1:0] hdr_vc = '0;
    logic [1:0] ecc_status = '0;
    logic       pay_crc_mismatch = 1'b0;
    logic [NV-1:0] ev_fs, ev_fe, ev_ls, ev_le, ev_crc_err, ev_ecc_fix;
    logic       ev_gen_short, ev_ecc_fatal;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Expected outputs for the last driven inputs.
    logic [NV-1:0] x_fs, x_fe, x_ls, x_le, x_crc, x_fix;
    logic          x_gen, x_fatal;

    always #5 clk = ~clk;

    csi2_hdr_event_det u0 (
        .clk(clk), .rst_n(rst_n), .hdr_vld(hdr_vld), .hdr_dt(hdr_dt), .hdr_vc(hdr_vc),
        .ecc_status(ecc_status), .pay_crc_mismatch(pay_crc_mismatch),
        .ev_fs(ev_fs), .ev_fe(ev_fe), .ev_ls(ev_ls), .ev_le(ev_le),
        .ev_crc_err(ev_crc_err), .ev_ecc_fix(ev_ecc_fix),
        .ev_gen_short(ev_gen_short), .ev_ecc_fatal(ev_ecc_fatal)
    );

    task automatic chk(input string tag, input string what, input logic [NV-1:0] act,
                       input logic [NV-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    // Reference model written from the requirements.
    task automatic model(input logic v, input logic [5:0] dt, input logic [1:0] vc,
                         input logic [1:0] ecc, input logic crc);
        logic [NV-1:0] ch;
        bit ok;
        ch = NV'(1) << vc;
        ok = v && !ecc[1];
        x_fs    = (ok && dt == 6'h00) ? ch : '0;                    // R2
        x_fe    = (ok && dt == 6'h01) ? ch : '0;
        x_ls    = (ok && dt == 6'h02) ? ch : '0;
        x_le    = (ok && dt == 6'h03) ? ch : '0;
        x_crc   = (ok && dt >= 6'h10 && crc) ? ch : '0;             // R6
        x_fix   = (ok && dt < 6'h10 && ecc == 2'b01) ? ch : '0;     // R4
        x_gen   = ok && dt >= 6'h08 && dt <= 6'h0F;                 // R3
        x_fatal = v && ecc[1];                                      // R5
    endtask

    // Compare every output against the expectation; tag by the requirement that owns it.
    task automatic check_all(input string ctx);
        string sync_tag;
        sync_tag = hdr_vld_prev ? "R2/R9" : "R7";
        chk(sync_tag, {ctx, " ev_fs"}, ev_fs, x_fs);
        chk(sync_tag, {ctx, " ev_fe"}, ev_fe, x_fe);
        chk(sync_tag, {ctx, " ev_ls"}, ev_ls, x_ls);
        chk(sync_tag, {ctx, " ev_le"}, ev_le, x_le);
        chk("R6", {ctx, " ev_crc_err"}, ev_crc_err, x_crc);
        chk("R4", {ctx, " ev_ecc_fix"}, ev_ecc_fix, x_fix);
        chk("R3", {ctx, " ev_gen_short"}, NV'(ev_gen_short), NV'(x_gen));
        chk("R5", {ctx, " ev_ecc_fatal"}, NV'(ev_ecc_fatal), NV'(x_fatal));
    endtask

    logic hdr_vld_prev = 1'b0;

    // Drive one cycle at the falling edge, then check one falling edge later
    // (the outputs update at the rising edge in between).
    task automatic step(input logic v, input logic [5:0] dt, input logic [1:0] vc,
                        input logic [1:0] ecc, input logic crc, input string ctx);
        hdr_vld = v; hdr_dt = dt; hdr_vc = vc; ecc_status = ecc; pay_crc_mismatch = crc;
        model(v, dt, vc, ecc, crc);
        hdr_vld_prev = v;
        @(negedge clk);
        check_all(ctx);
    endtask

    initial begin
        void'($urandom(32'h5EED_0C51));
        // R1: reset holds outputs low even with a strobe present.
        hdr_vld = 1'b1; hdr_dt = 6'h00; ecc_status = 2'b01;
        repeat (3) @(negedge clk);
        x_fs = '0; x_fe = '0; x_ls = '0; x_le = '0; x_crc = '0; x_fix = '0;
        x_gen = 1'b0; x_fatal = 1'b0;
        hdr_vld_prev = 1'b0;
        chk("R1", "reset ev_fs", ev_fs, '0);
        chk("R1", "reset ev_ecc_fix", ev_ecc_fix, '0);
        chk("R1", "reset ev_gen_short", NV'(ev_gen_short), '0);
        rst_n = 1'b1;
        hdr_vld = 1'b0;

        // R2 / R9: every sync code on every channel.
        for (int c = 0; c < 4; c++)
            for (int d = 0; d < NV; d++)
                step(1'b1, 6'(c), 2'(d), 2'b00, 1'b0, "R2 sync sweep");
        // R8: idle right after a pulse returns to zero.
        step(1'b0, 6'h00, 2'd0, 2'b00, 1'b0, "R8 pulse ends");
        // R3 boundaries.
        step(1'b1, 6'h07, 2'd1, 2'b00, 1'b0, "R3 type 0x07 reserved");
        step(1'b1, 6'h08, 2'd1, 2'b00, 1'b0, "R3 type 0x08");
        step(1'b1, 6'h0F, 2'd2, 2'b00, 1'b0, "R3 type 0x0F");
        step(1'b1, 6'h04, 2'd2, 2'b00, 1'b1, "R3/R6 type 0x04 crc ignored");
        // R6 long packet checksum, boundary 0x10.
        step(1'b1, 6'h10, 2'd3, 2'b00, 1'b1, "R6 type 0x10 crc");
        step(1'b1, 6'h3F, 2'd0, 2'b00, 1'b1, "R6 type 0x3F crc");
        step(1'b1, 6'h0F, 2'd0, 2'b00, 1'b1, "R6 short crc ignored");
        // R4 corrected ECC: short yes, long no, sync with fix on both outputs.
        step(1'b1, 6'h01, 2'd2, 2'b01, 1'b0, "R4 FE corrected");
        step(1'b1, 6'h05, 2'd3, 2'b01, 1'b0, "R4 reserved corrected");
        step(1'b1, 6'h22, 2'd1, 2'b01, 1'b1, "R4 long corrected no fix");
        // R5 uncorrectable suppresses everything.
        step(1'b1, 6'h00, 2'd1, 2'b10, 1'b0, "R5 FS uncorrectable");
        step(1'b1, 6'h2A, 2'd2, 2'b11, 1'b1, "R5 long uncorrectable");
        step(1'b1, 6'h09, 2'd3, 2'b10, 1'b0, "R5 generic uncorrectable");
        // R7 idle with busy fields.
        step(1'b0, 6'h00, 2'd3, 2'b01, 1'b1, "R7 idle fields");
        step(1'b0, 6'h3F, 2'd0, 2'b10, 1'b1, "R7 idle fatal code");
        // R8 back-to-back identical strobes give back-to-back pulses.
        step(1'b1, 6'h02, 2'd1, 2'b00, 1'b0, "R8 back-to-back 1");
        step(1'b1, 6'h02, 2'd1, 2'b00, 1'b0, "R8 back-to-back 2");

        // Random mix.
        for (int i = 0; i < 3000; i++) begin
            logic [5:0] rdt;
            rdt = ($urandom % 3 == 0) ? 6'($urandom % 16) : 6'($urandom);
            step(($urandom % 4) != 0, rdt, 2'($urandom), 2'($urandom), 1'($urandom),
                 "random");
        end
        step(1'b0, 6'h00, 2'd0, 2'b00, 1'b0, "R7 final idle");
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #1_000_000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule